// File: doc/BRIEF.md
# Calendar-Driven FIFO Status Channel Generator

This block drives a 2-bit FIFO status channel one symbol per clock. Each frame opens with a framing symbol (`2'b11`), carries one status symbol for every calendar slot, repeated a programmable number of times, and closes with a 2-bit diagonal parity code. For each slot the block looks up a port address in the active calendar table and presents it on a request interface. The external status source answers in the same cycle, and that answer goes straight onto the channel. How FIFO fill levels become status values is the business of the source, not of this block.

Two calendar tables are held, each with its own length and repeat count. A select input chooses the table for the next frame, and the change takes effect only at a frame boundary. A small write port programs the tables. Writes to the table in use are dropped unless the channel is switched off. Three controls act on the running channel:
- A switch-off input forces continuous framing symbols and raises a flag.
- A retrain input forces framing symbols without raising the flag.
- A parity-corruption input inverts the parity code of the current frame.

Top module: `status_cal_gen`

## Requirements
- R1: After reset, and after every parity symbol, the channel carries one framing symbol `2'b11` with `req_valid` low. Reset tables hold entry i = port i, length CAL_DEPTH and multiplier 1.
- R2: In status slot k of a frame, `req_valid` is high and `req_port` equals entry k of the active table. `stat_o` equals `fifo_stat` in that same cycle.
- R3: The slot sequence 0..length-1 is repeated multiplier times, where the multiplier ranges from 1 to 256. The parity symbol follows the final slot directly.
- R4: The parity symbol is the complement of a 2-bit accumulator that starts at 0 each frame. The accumulator XORs in each status symbol at even frame positions (0, 2, …) as {b1,b0}, and at odd positions with its bits swapped as {b0,b1}.
- R5: If `dip_flip` is high in any status slot of a frame, or in its parity cycle, both bits of that frame's parity symbol are inverted. Status symbols are never altered, and the next frame's parity is unaffected.
- R6: While `chan_off` is high, `stat_o` is `2'b11`, `off_o` is high and `req_valid` is low. After release, a new frame starts with a framing symbol.
- R7: While `retrain_req` is high, `stat_o` is `2'b11`, `req_valid` is low and `off_o` stays low. After release, a new frame starts with a framing symbol.
- R8: `cal_pick` is sampled only in the framing cycle. A change during a frame does not alter the slots of that frame.
- R9: A write whose `cfg_tbl` is the active table is ignored while the channel is on. Writes to the other table, and any write while `chan_off` is high, take effect.
- R10: Write encoding by `cfg_field`:
  - 0 stores `cfg_data[PORT_W-1:0]` as entry `cfg_idx`.
  - 1 stores length-1 from `cfg_data[LEN_W-1:0]`.
  - 2 stores multiplier-1 from `cfg_data`.
  - A frame then holds exactly length × multiplier status slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_off | input | 1 | Switch channel off (continuous framing) |
| retrain_req | input | 1 | Force framing symbols to request retraining |
| dip_flip | input | 1 | Invert the parity code of the current frame |
| cal_pick | input | 1 | Calendar table for the next frame |
| cfg_wr | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | Table written |
| cfg_field | input | 2 | 0 entry, 1 length-1, 2 multiplier-1 |
| cfg_idx | input | LEN_W | Entry index |
| cfg_data | input | MULT_W | Write data |
| req_valid | output | 1 | Status request valid |
| req_port | output | PORT_W | Port whose status is requested |
| fifo_stat | input | 2 | Status answer for `req_port` |
| stat_o | output | 2 | Status channel symbol |
| off_o | output | 1 | Channel is switched off |

## Verification
On every cycle, the assertions check the following:
- Switch-off and retrain force framing symbols and suppress requests.
- A requested status passes to the channel unchanged.
- A parity symbol is always followed by a framing state.
- The active table changes only out of a framing cycle.
- The slot counter stays within the programmed length.

The bench's frame-by-frame scenarios are needed for the rest:
- The order in which ports are requested.
- The repetition count.
- The diagonal parity value and its single-frame inversion.
- Rejection of writes to the active table.
- The deferred effect of a mid-frame select change.

// File: rtl/status_cal_gen.sv
module status_cal_gen #(
  parameter int NUM_PORTS = 8,
  parameter int CAL_DEPTH = 4,
  parameter int MULT_W    = 8,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int LEN_W  = (CAL_DEPTH > 1) ? $clog2(CAL_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_off,
  input  logic              retrain_req,
  input  logic              dip_flip,
  input  logic              cal_pick,
  input  logic              cfg_wr,
  input  logic              cfg_tbl,
  input  logic [1:0]        cfg_field,
  input  logic [LEN_W-1:0]  cfg_idx,
  input  logic [MULT_W-1:0] cfg_data,
  output logic              req_valid,
  output logic [PORT_W-1:0] req_port,
  input  logic [1:0]        fifo_stat,
  output logic [1:0]        stat_o,
  output logic              off_o
);

  typedef enum logic [1:0] {S_FRM = 2'd0, S_SLOT = 2'd1, S_DIP = 2'd2} st_t;

  st_t               st_q;
  logic              act_q;
  logic [LEN_W-1:0]  slot_q;
  logic [MULT_W-1:0] rep_q;
  logic              par_q, err_q;
  logic [1:0]        acc_q;

  logic [PORT_W-1:0] ent_q [2][CAL_DEPTH];
  logic [LEN_W-1:0]  len_q [2];
  logic [MULT_W-1:0] mul_q [2];

  wire run       = !chan_off && !retrain_req;
  wire slot_last = (slot_q == len_q[act_q]);
  wire rep_last  = (rep_q == mul_q[act_q]);
  wire [1:0] sym = par_q ? {fifo_stat[0], fifo_stat[1]} : fifo_stat;
  wire tbl_busy  = (cfg_tbl == act_q) || (st_q == S_FRM && cfg_tbl == cal_pick);
  wire wr_ok     = cfg_wr && (chan_off || !tbl_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        for (int i = 0; i < CAL_DEPTH; i++) ent_q[t][i] <= PORT_W'(i % NUM_PORTS);
        len_q[t] <= LEN_W'(CAL_DEPTH - 1);
        mul_q[t] <= '0;
      end
    end else if (wr_ok) begin
      case (cfg_field)
        2'd0: if (int'(cfg_idx) < CAL_DEPTH) ent_q[cfg_tbl][cfg_idx] <= cfg_data[PORT_W-1:0];
        2'd1: len_q[cfg_tbl] <= cfg_data[LEN_W-1:0];
        2'd2: mul_q[cfg_tbl] <= cfg_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_FRM;
      act_q  <= 1'b0;
      slot_q <= '0;
      rep_q  <= '0;
      par_q  <= 1'b0;
      err_q  <= 1'b0;
      acc_q  <= 2'b00;
    end else if (!run) begin
      st_q <= S_FRM;
    end else begin
      case (st_q)
        S_FRM: begin
          st_q   <= S_SLOT;
          act_q  <= cal_pick;
          slot_q <= '0;
          rep_q  <= '0;
          par_q  <= 1'b0;
          err_q  <= 1'b0;
          acc_q  <= 2'b00;
        end
        S_SLOT: begin
          acc_q <= acc_q ^ sym;
          par_q <= ~par_q;
          err_q <= err_q | dip_flip;
          if (slot_last) begin
            slot_q <= '0;
            if (rep_last) st_q <= S_DIP;
            else          rep_q <= rep_q + 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        default: st_q <= S_FRM;
      endcase
    end
  end

  assign off_o     = chan_off;
  assign req_valid = run && (st_q == S_SLOT);
  assign req_port  = ent_q[act_q][slot_q];
  assign stat_o    = req_valid ? fifo_stat :
                     (run && st_q == S_DIP) ? (~acc_q ^ {2{err_q | dip_flip}}) : 2'b11;

endmodule

// File: rtl/status_cal_gen_chk.sv
module status_cal_gen_chk #(
  parameter int LEN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_off,
  input logic             retrain_req,
  input logic             req_valid,
  input logic [1:0]       fifo_stat,
  input logic [1:0]       stat_o,
  input logic             off_o,
  input logic [1:0]       st,
  input logic             act,
  input logic [LEN_W-1:0] slot,
  input logic [LEN_W-1:0] len_act
);

  p_off_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    off_o |-> (stat_o == 2'b11 && !req_valid));

  p_retrain_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retrain_req && !chan_off) |-> (stat_o == 2'b11 && !off_o && !req_valid));

  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (stat_o == fifo_stat));

  p_frame_after_dip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |=> (st == 2'd0));

  p_sel_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> ($past(st) == 2'd0));

  p_slot_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (slot <= len_act));

endmodule

bind status_cal_gen status_cal_gen_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_off(chan_off), .retrain_req(retrain_req),
  .req_valid(req_valid), .fifo_stat(fifo_stat), .stat_o(stat_o), .off_o(off_o),
  .st(st_q), .act(act_q), .slot(slot_q), .len_act(len_q[act_q])
);

// File: tb/tb_status_cal_gen.sv
module tb_status_cal_gen;
  localparam int NP = 8, CD = 4, MW = 8, PW = 3, LW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, chan_off, retrain_req, dip_flip, cal_pick, cfg_wr, cfg_tbl;
  logic [1:0] cfg_field;
  logic [LW-1:0] cfg_idx;
  logic [MW-1:0] cfg_data;
  logic req_valid, off_o;
  logic [PW-1:0] req_port;
  logic [1:0] fifo_stat, stat_o, salt;

  assign fifo_stat = req_port[1:0] + salt;

  status_cal_gen dut (
    .clk(clk), .rst_n(rst_n), .chan_off(chan_off), .retrain_req(retrain_req),
    .dip_flip(dip_flip), .cal_pick(cal_pick), .cfg_wr(cfg_wr), .cfg_tbl(cfg_tbl),
    .cfg_field(cfg_field), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_port(req_port), .fifo_stat(fifo_stat),
    .stat_o(stat_o), .off_o(off_o)
  );

  int n_chk = 0, n_bad = 0;
  int m_ent [2][CD];
  int m_len [2];
  int m_mul [2];
  bit pend = 0;
  int p_t, p_f, p_i, p_d;

  function automatic logic [1:0] fs(int p);
    logic [1:0] v;
    v = 2'(p) + salt;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic upd(int t, int f, int i, int d);
    if (f == 0) m_ent[t][i] = d;
    else if (f == 1) m_len[t] = d + 1;
    else if (f == 2) m_mul[t] = d + 1;
  endtask

  task automatic cyc();
    @(negedge clk);
    cfg_wr = 1'b0;
    dip_flip = 1'b0;
  endtask

  task automatic wr(int t, int f, int i, int d);
    cyc();
    cfg_wr = 1'b1; cfg_tbl = t[0]; cfg_field = 2'(f); cfg_idx = LW'(i); cfg_data = MW'(d);
    upd(t, f, i, d);
  endtask

  task automatic go_off();
    cyc();
    chan_off = 1'b1;
    #1;
    chk(off_o && stat_o == 2'b11 && !req_valid, "R6 switched off", int'(stat_o), 3);
  endtask

  task automatic setcal(int t, int len, int mul, int base);
    for (int i = 0; i < len; i++) wr(t, 0, i, (base + i * 3) % NP);
    wr(t, 1, 0, len - 1);
    wr(t, 2, 0, mul - 1);
  endtask

  task automatic partial(int t, int m);
    cyc();
    chan_off = 1'b0; retrain_req = 1'b0; cal_pick = t[0];
    repeat (m) cyc();
  endtask

  task automatic frame(int t, int inj, bit sw);
    logic [1:0] acc, s, expd;
    int n, e;
    cyc();
    chan_off = 1'b0; retrain_req = 1'b0; cal_pick = t[0];
    #1;
    chk(stat_o == 2'b11 && !req_valid, "R1 framing symbol", int'(stat_o), 3);
    acc = 2'b00; n = 0;
    for (int r = 0; r < m_mul[t]; r++) begin
      for (int k = 0; k < m_len[t]; k++) begin
        cyc();
        if (n == 0 && pend) begin
          cfg_wr = 1'b1; cfg_tbl = p_t[0]; cfg_field = 2'(p_f); cfg_idx = LW'(p_i); cfg_data = MW'(p_d);
        end
        if (n == 0 && sw) cal_pick = (t == 0);
        if (n == inj) dip_flip = 1'b1;
        #1;
        e = m_ent[t][k];
        chk(req_valid && int'(req_port) == e, (r > 0) ? "R3 repeated slot port" : "R2 slot port",
            int'(req_port), e);
        s = fs(e);
        chk(stat_o == s, "R2 status pass-through", int'(stat_o), int'(s));
        acc = acc ^ ((n % 2 == 1) ? {s[0], s[1]} : s);
        n++;
      end
    end
    if (pend) begin
      if (p_t != t) upd(p_t, p_f, p_i, p_d);
      pend = 0;
    end
    cyc();
    if (inj == n) dip_flip = 1'b1;
    #1;
    chk(!req_valid, "R10 frame holds length x multiplier slots", int'(req_valid), 0);
    expd = ~acc ^ ((inj >= 0) ? 2'b11 : 2'b00);
    chk(stat_o == expd, (inj >= 0) ? "R5 inverted parity" : "R4 diagonal parity",
        int'(stat_o), int'(expd));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; chan_off = 1; retrain_req = 0; dip_flip = 0; cal_pick = 0;
    cfg_wr = 0; cfg_tbl = 0; cfg_field = 0; cfg_idx = 0; cfg_data = 0; salt = 0;
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < CD; i++) m_ent[t][i] = i;
      m_len[t] = CD; m_mul[t] = 1;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(stat_o == 2'b11 && !req_valid && off_o, "R1 reset state", int'(stat_o), 3);
    @(negedge clk); rst_n = 1;
    // R1: reset-default tables
    frame(0, -1, 0);
    frame(1, -1, 0);

    // R3 R10 sweep over tables, lengths and multipliers
    for (int t = 0; t < 2; t++)
      for (int len = 1; len <= CD; len++)
        for (int mul = 1; mul <= 3; mul++) begin
          go_off();
          salt = 2'(len + mul + t);
          setcal(t, len, mul, t * 5 + len);
          frame(t, -1, 0);
          frame(t, -1, 0);
        end

    // R3 maximum multiplier
    go_off();
    setcal(1, 1, 256, 6);
    frame(1, -1, 0);

    // R5 parity corruption at several points
    go_off();
    salt = 2'd1;
    setcal(0, 3, 2, 1);
    frame(0, 2, 0);
    frame(0, -1, 0);
    frame(0, 0, 0);
    frame(0, 6, 0);
    frame(0, -1, 0);

    // R9 write protection
    go_off();
    setcal(0, 4, 1, 2);
    setcal(1, 2, 1, 3);
    pend = 1; p_t = 0; p_f = 1; p_i = 0; p_d = 0;
    frame(0, -1, 0);
    frame(0, -1, 0);
    pend = 1; p_t = 1; p_f = 0; p_i = 0; p_d = 7;
    frame(0, -1, 0);
    frame(1, -1, 0);
    go_off();
    wr(1, 1, 0, 2);
    frame(1, -1, 0);

    // R8 mid-frame select change
    frame(0, -1, 1);
    frame(1, -1, 0);
    frame(0, -1, 1);
    frame(1, -1, 0);

    // R6 switch-off mid-frame, restart
    partial(0, 2);
    go_off();
    go_off();
    frame(0, -1, 0);

    // R7 retrain mid-frame, restart
    partial(1, 2);
    cyc();
    retrain_req = 1'b1;
    #1;
    chk(stat_o == 2'b11 && !off_o && !req_valid, "R7 retrain framing", int'(stat_o), 3);
    cyc();
    #1;
    chk(stat_o == 2'b11 && !off_o && !req_valid, "R7 retrain framing held", int'(stat_o), 3);
    frame(1, -1, 0);
    frame(0, -1, 0);

    summary();
    $finish;
  end
endmodule